// File: doc/BRIEF.md
# Sound Coprocessor Address Decoder

This block sits between the core of a small sound coprocessor and its local storage. It takes one byte access per clock on a 16-bit address, and sends it to one of four RAM regions or to a bank of sixteen byte-wide I/O registers. The registers are placed in a hole at the top of page zero. The four regions are a direct page, a stack page, a main RAM and a writable boot area. The timers, the mixing engine and the host mailbox handshake live elsewhere. Here their registers are plain storage with fixed access rights. The block flags any access those rights forbid.

Main RAM spans 0x0200 to 0xFFBF in the address map. Only its first `MAIN_BYTES` bytes are built. The default keeps elaboration small, and setting the parameter to 0xFDC0 gives the full region. An access above the built part is treated as a forbidden access.

Top module: `sdec_top`

## Requirements
- R1: Addresses 0x0000 to 0x00EF reach a 240-byte direct-page RAM at offset equal to the address.
- R2: Addresses 0x0100 to 0x01FF reach a 256-byte stack RAM at offset address minus 0x0100.
- R3: Addresses from 0x0200 to 0x0200+MAIN_BYTES-1 reach main RAM at offset address minus 0x0200. An access from 0x0200+MAIN_BYTES up to 0xFFBF is forbidden: it drops a write and reads as 0x00.
- R4: Addresses 0xFFC0 to 0xFFFF reach a 64-byte boot RAM at offset address minus 0xFFC0, and it accepts writes.
- R5: Registers 0xF0 and 0xF2 to 0xF9 read back the last byte written to them.
- R6: Registers 0xF1, 0xFA, 0xFB and 0xFC accept writes without error. A read of any of them is forbidden and returns 0x00.
- R7: Registers 0xFD, 0xFE and 0xFF read as 0x00. A write to any of them is forbidden and leaves their value at 0x00.
- R8: Read data appears on `rd_data` in the clock after a read is sampled (`acc_en`=1, `wr_en`=0). It holds its value through write cycles and idle cycles.
- R9: `acc_fault` is high for exactly the one clock after each forbidden access is sampled, and low otherwise.
- R10: After reset, `rd_data` and `acc_fault` are 0, and every register and RAM byte reads 0x00.
- R11: A write to one region or register leaves every other region and register unchanged: no two address ranges alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | An access is presented this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Byte address |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| acc_fault | output | 1 | One-cycle pulse after a forbidden access |

## Verification
Two things can happen on the ports in the same cycle. The result of one access (its read byte or its fault pulse) appears while the next access is being sampled. The bench drives runs of back-to-back accesses with no gaps: a read followed at once by a write to the same byte, a forbidden read followed by a legal one, and a forbidden write followed by a read. A behavioural reference model predicts `rd_data` and `acc_fault` for every clock, so it catches a result that is late, merged with its neighbour, or wrongly overwritten by the following write.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

   localparam int unsigned ADDR_W   = 16;
   localparam int unsigned DATA_W   = 8;
   localparam int unsigned DP_BYTES = 240;
   localparam int unsigned SP_BYTES = 256;
   localparam int unsigned BT_BYTES = 64;
   localparam int unsigned IO_REGS  = 16;
   localparam int unsigned MAIN_MAX = 32'hFDC0;

   localparam logic [ADDR_W-1:0] SP_BASE = 16'h0100;
   localparam logic [ADDR_W-1:0] MN_BASE = 16'h0200;
   localparam logic [ADDR_W-1:0] BT_BASE = 16'hFFC0;
   localparam logic [ADDR_W-1:0] IO_BASE = 16'h00F0;

   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_DP   = 3'd1,
      SRC_SP   = 3'd2,
      SRC_MAIN = 3'd3,
      SRC_BOOT = 3'd4,
      SRC_IO   = 3'd5
   } src_e;

   typedef enum logic [1:0] {
      ACC_RW = 2'd0,
      ACC_WO = 2'd1,
      ACC_RO = 2'd2
   } acc_e;

   typedef struct packed {
      src_e              src;
      logic [ADDR_W-1:0] off;
      logic              rd_ok;
      logic              wr_ok;
   } dec_t;

   function automatic acc_e io_kind(input int unsigned idx);
      case (idx)
         1, 10, 11, 12: return ACC_WO;
         13, 14, 15:    return ACC_RO;
         default:       return ACC_RW;
      endcase
   endfunction

endpackage

// File: rtl/sdec_decode.sv
module sdec_decode
   import sdec_pkg::*;
#(
   parameter int unsigned MAIN_BYTES = 1024
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   localparam logic [ADDR_W-1:0] MN_END = ADDR_W'(MN_BASE + MAIN_BYTES);

   logic [3:0] io_idx;
   acc_e       io_acc;

   assign io_idx = addr[3:0];

   always_comb begin
      io_acc = ACC_RW;
      for (int unsigned k = 0; k < IO_REGS; k++) begin
         if (io_idx == 4'(k)) io_acc = io_kind(k);
      end
   end

   always_comb begin
      dec.src   = SRC_NONE;
      dec.off   = '0;
      dec.rd_ok = 1'b0;
      dec.wr_ok = 1'b0;
      if (addr < IO_BASE) begin
         dec.src = SRC_DP;  dec.off = addr;
         dec.rd_ok = 1'b1;  dec.wr_ok = 1'b1;
      end else if (addr < SP_BASE) begin
         dec.src   = SRC_IO;
         dec.off   = {12'h000, io_idx};
         dec.rd_ok = (io_acc != ACC_WO);
         dec.wr_ok = (io_acc != ACC_RO);
      end else if (addr < MN_BASE) begin
         dec.src = SRC_SP;  dec.off = addr - SP_BASE;
         dec.rd_ok = 1'b1;  dec.wr_ok = 1'b1;
      end else if (addr >= BT_BASE) begin
         dec.src = SRC_BOOT; dec.off = addr - BT_BASE;
         dec.rd_ok = 1'b1;   dec.wr_ok = 1'b1;
      end else if ({1'b0, addr} < {1'b0, MN_END} || MAIN_BYTES == MAIN_MAX) begin
         dec.src = SRC_MAIN; dec.off = addr - MN_BASE;
         dec.rd_ok = 1'b1;   dec.wr_ok = 1'b1;
      end
   end

endmodule

// File: rtl/sdec_ram.sv
module sdec_ram
   import sdec_pkg::*;
#(
   parameter int unsigned DEPTH          = 256,
   parameter bit          CLEAR_ON_RESET = 1'b1,
   localparam int unsigned AW            = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("sdec_ram: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int unsigned i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (en && we) begin
            mem[addr] <= wdata;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (en && we) mem[addr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          rdata <= '0;
      else if (en && !we)  rdata <= mem[addr];
   end

endmodule

// File: rtl/sdec_iobank.sv
module sdec_iobank
   import sdec_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [3:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] regs [IO_REGS];
   logic [IO_REGS-1:0] readable;

   for (genvar i = 0; i < IO_REGS; i++) begin : g_reg
      localparam acc_e KIND = io_kind(i);
      assign readable[i] = (KIND != ACC_WO);
      if (KIND == ACC_RO) begin : g_ro
         always_ff @(posedge clk) regs[i] <= '0;
      end else begin : g_wr
         always_ff @(posedge clk) begin
            if (!rst_n)                           regs[i] <= '0;
            else if (en && we && idx == 4'(i))    regs[i] <= wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         rdata <= '0;
      else if (en && !we) rdata <= readable[idx] ? regs[idx] : '0;
   end

endmodule

// File: rtl/sdec_top.sv
module sdec_top
   import sdec_pkg::*;
#(
   parameter int unsigned MAIN_BYTES     = 1024,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_en,
   input  logic        wr_en,
   input  logic [15:0] addr,
   input  logic [7:0]  wr_data,
   output logic [7:0]  rd_data,
   output logic        acc_fault
);
   localparam int unsigned DP_AW = $clog2(DP_BYTES);
   localparam int unsigned SP_AW = $clog2(SP_BYTES);
   localparam int unsigned MN_AW = $clog2(MAIN_BYTES);
   localparam int unsigned BT_AW = $clog2(BT_BYTES);

   if (MAIN_BYTES < 2 || MAIN_BYTES > MAIN_MAX) begin : g_bad_main
      $error("sdec_top: MAIN_BYTES out of range");
   end

   dec_t dec;
   logic go;
   logic en_dp, en_sp, en_mn, en_bt, en_io;
   logic [7:0] q_dp, q_sp, q_mn, q_bt, q_io;
   src_e src_q;

   sdec_decode #(.MAIN_BYTES(MAIN_BYTES)) u_dec (.addr(addr), .dec(dec));

   assign go    = acc_en && (wr_en ? dec.wr_ok : dec.rd_ok);
   assign en_dp = go && dec.src == SRC_DP;
   assign en_sp = go && dec.src == SRC_SP;
   assign en_mn = go && dec.src == SRC_MAIN;
   assign en_bt = go && dec.src == SRC_BOOT;
   assign en_io = go && dec.src == SRC_IO;

   sdec_ram #(.DEPTH(DP_BYTES), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_dp (
      .clk(clk), .rst_n(rst_n), .en(en_dp), .we(wr_en),
      .addr(dec.off[DP_AW-1:0]), .wdata(wr_data), .rdata(q_dp));
   sdec_ram #(.DEPTH(SP_BYTES), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_sp (
      .clk(clk), .rst_n(rst_n), .en(en_sp), .we(wr_en),
      .addr(dec.off[SP_AW-1:0]), .wdata(wr_data), .rdata(q_sp));
   sdec_ram #(.DEPTH(MAIN_BYTES), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_mn (
      .clk(clk), .rst_n(rst_n), .en(en_mn), .we(wr_en),
      .addr(dec.off[MN_AW-1:0]), .wdata(wr_data), .rdata(q_mn));
   sdec_ram #(.DEPTH(BT_BYTES), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_bt (
      .clk(clk), .rst_n(rst_n), .en(en_bt), .we(wr_en),
      .addr(dec.off[BT_AW-1:0]), .wdata(wr_data), .rdata(q_bt));
   sdec_iobank u_io (
      .clk(clk), .rst_n(rst_n), .en(en_io), .we(wr_en),
      .idx(dec.off[3:0]), .wdata(wr_data), .rdata(q_io));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q     <= SRC_NONE;
         acc_fault <= 1'b0;
      end else begin
         acc_fault <= acc_en && !go;
         if (acc_en && !wr_en) src_q <= go ? dec.src : SRC_NONE;
      end
   end

   always_comb begin
      case (src_q)
         SRC_DP:   rd_data = q_dp;
         SRC_SP:   rd_data = q_sp;
         SRC_MAIN: rd_data = q_mn;
         SRC_BOOT: rd_data = q_bt;
         SRC_IO:   rd_data = q_io;
         default:  rd_data = 8'h00;
      endcase
   end

   // R11: one target at most per access
   p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({en_dp, en_sp, en_mn, en_bt, en_io}));

   p_fault_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fault |-> $past(acc_en));

   p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fault && !$past(wr_en)) |-> rd_data == 8'h00);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!acc_en || wr_en) |-> $stable(rd_data));

   p_ro_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && wr_en && addr >= 16'h00FD && addr <= 16'h00FF) |=> acc_fault);

   p_wo_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !wr_en && (addr == 16'h00F1 || (addr >= 16'h00FA && addr <= 16'h00FC)))
      |=> acc_fault);

   p_boot_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && addr >= 16'hFFC0) |=> !acc_fault);

endmodule

// File: tb/sdec_top_bench.sv
module sdec_top_bench;
   localparam int MB = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       acc_fault;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] mdl [65536];
   logic [7:0] exp_rd = 8'h00;
   logic       exp_flt = 1'b0;
   string      exp_tag = "R10";

   always #2 clk = ~clk;

   sdec_top #(.MAIN_BYTES(MB)) u_sdec_top (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .acc_fault(acc_fault));

   function automatic bit is_ro(int a);  return a >= 'hFD && a <= 'hFF; endfunction
   function automatic bit is_wo(int a);  return a == 'hF1 || (a >= 'hFA && a <= 'hFC); endfunction
   function automatic bit is_gap(int a); return a >= 'h200 + MB && a <= 'hFFBF; endfunction
   function automatic bit rd_ok(int a);  return !is_wo(a) && !is_gap(a); endfunction
   function automatic bit wr_ok(int a);  return !is_ro(a) && !is_gap(a); endfunction

   function automatic string tag_of(int a);
      if (a <= 'hEF)       return "R1";
      if (a <= 'hFF)       return is_ro(a) ? "R7" : (is_wo(a) ? "R6" : "R5");
      if (a <= 'h1FF)      return "R2";
      if (a <= 'hFFBF)     return "R3";
      return "R4";
   endfunction

   task automatic compare();
      checks += 2;
      if (rd_data !== exp_rd) begin
         failures++;
         $display("FAIL %s rd_data actual=%02h expected=%02h", exp_tag, rd_data, exp_rd);
      end
      if (acc_fault !== exp_flt) begin
         failures++;
         $display("FAIL R9 (%s) acc_fault actual=%0b expected=%0b", exp_tag, acc_fault, exp_flt);
      end
   endtask

   // one clock: check previous result, present next access, advance model
   task automatic step(bit c, bit w, int a, logic [7:0] d, string t);
      @(negedge clk);
      compare();
      acc_en = c; wr_en = w; addr = 16'(a); wr_data = d;
      if (!c) begin
         exp_flt = 1'b0;
         exp_tag = (t == "") ? "R8" : t;
      end else begin
         exp_tag = (t == "") ? tag_of(a) : t;
         if (w) begin
            exp_flt = !wr_ok(a);
            if (wr_ok(a)) mdl[a] = d;
         end else begin
            exp_flt = !rd_ok(a);
            exp_rd  = rd_ok(a) ? mdl[a] : 8'h00;
         end
      end
   endtask

   task automatic wr(int a, logic [7:0] d, string t = ""); step(1, 1, a, d, t); endtask
   task automatic rd(int a, string t = "");               step(1, 0, a, 8'h00, t); endtask
   task automatic idle();                                 step(0, 0, 0, 8'h00, ""); endtask

   int bnd [8];

   initial begin
      for (int i = 0; i < 65536; i++) mdl[i] = 8'h00;
      bnd = '{'h0000, 'h00EF, 'h0100, 'h01FF, 'h0200, 'h0200 + MB - 1, 'hFFC0, 'hFFFF};
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state, then untouched bytes read zero
      step(0, 0, 0, 8'h00, "R10");
      rd('h0010, "R10"); rd('h0150, "R10"); rd('h0300, "R10"); rd('hFFD0, "R10"); rd('h00F4, "R10");
      idle();
      // R1 R2 R3 R4: unique pattern at each region boundary
      foreach (bnd[k]) wr(bnd[k], 8'(8'hA1 + 8'(k * 29)));
      foreach (bnd[k]) rd(bnd[k]);
      // R11: neighbours of every boundary and same offsets in other regions stay zero
      foreach (bnd[k]) begin
         if (bnd[k] > 0)       rd(bnd[k] - 1, "R11");
         if (bnd[k] < 'hFFFF)  rd(bnd[k] + 1, "R11");
      end
      rd('h0040, "R11"); wr('h0140, 8'h3C); wr('h0240, 8'h4D); wr('hFFC0 + 'h20, 8'h5E);
      rd('h0040, "R11"); rd('h0140, "R11"); rd('h0240, "R11"); rd('h0020, "R11");
      // R5 R6 R7: the register hole, every byte written then read
      for (int r = 'hF0; r <= 'hFF; r++) wr(r, 8'(r ^ 8'h69));
      for (int r = 'hF0; r <= 'hFF; r++) rd(r);
      rd('h00EF, "R11"); rd('h0100, "R11");
      // R3: above the built part of main RAM
      wr('h0200 + MB, 8'h77); rd('h0200 + MB); wr('hFFBF, 8'h88); rd('hFFBF); rd('h8000);
      // R8 R9: back-to-back pairs, holding across writes and idles
      rd('h0050); wr('h0050, 8'hC7); rd('h0050);
      rd('h00F1); rd('h00F4); wr('h00FE, 8'h12); rd('h00FE);
      rd('h0060); idle(); idle(); wr('h0061, 8'h99); idle(); rd('h0061);
      rd('hFFFE); rd('h00FA); wr('hFFFE, 8'h21); rd('hFFFE);
      // random mix of all regions, checked every clock
      for (int n = 0; n < 4000; n++) begin
         int a;
         int sel = int'($urandom_range(0, 8));
         case (sel)
            0: a = int'($urandom_range(0, 'hEF));
            1: a = int'($urandom_range('h100, 'h1FF));
            2: a = int'($urandom_range('h200, 'h200 + MB - 1));
            3: a = int'($urandom_range('h200 + MB, 'hFFBF));
            4: a = int'($urandom_range('hFFC0, 'hFFFF));
            5, 6: a = int'($urandom_range('hF0, 'hFF));
            default: a = bnd[$urandom_range(0, 7)];
         endcase
         if ($urandom_range(0, 9) == 0) idle();
         else step(1, 1'($urandom_range(0, 1)), a, 8'($urandom), "");
      end
      idle();
      idle();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule